// File: doc/BRIEF.md
# Round-Robin Shared-Port Arbiter for AXI4-Lite

This block lets several AXI4-Lite masters share one AXI4-Lite slave port. The write path and the read path each have their own arbiter. Each arbiter grants one master at a time and holds that grant from the address handshake until the matching response has been accepted. A master that keeps requesting keeps the grant. When the granted master stops requesting, the grant moves on in round-robin order, starting from the master after the one that held it last. Only one transaction is in flight on each path.

Each path runs one state machine with three states:
- `ST_IDLE`: no grant, and every master-side ready and slave-side valid is low. The transition *arbitrate* moves to `ST_ADDR` when any master requests.
- `ST_ADDR`: the granted master's address (and, on the write path, its data) is forwarded. Write address and data are tracked separately, each forwarded only until it is accepted. The transition *issued* moves to `ST_RESP` once both have been accepted, or once the address alone has been accepted on the read path.
- `ST_RESP`: the slave's response is routed to the granted master. On the response handshake, the transition *keep* returns to `ST_ADDR` with the same master if that master's address valid is high in the same cycle. Otherwise the transition *release* goes to `ST_IDLE`.

Top module: `axil_rr_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, no master sees a ready or a response valid and the slave sees no valid. After reset, master 0 has the highest priority.
- R2: Suppose a master raises its next address valid by the cycle in which its previous response is accepted. It then keeps the grant, so with three masters each doing four such writes the slave sees the order m0 x4, m1 x4, m2 x4. The read path behaves the same way.
- R3: A master that has no address valid high when its response is accepted loses the grant. The next grant goes to the first requester after the last granted master. Masters with idle gaps are therefore served m0, m1, m2, m0, and so on, and a master that is not requesting is skipped.
- R4: A path never forwards a new address to the slave until the previous response on that path has been accepted, whatever the response latency (tested with 0 and 3 cycles).
- R5: At most one master sees an address ready, a write-data ready or a response valid on each path. Masters that are not granted see zero response code and zero read data.
- R6: The read and write paths are arbitrated independently and may serve different masters at the same time.
- R7: The response code and the read data reach the granted master unchanged (OKAY = 2'b00, SLVERR = 2'b10).
- R8: The slave receives the granted master's write address, write data and byte strobes. Each is forwarded exactly once per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awvalid | input | N | Write address valid, one bit per master |
| m_awready | output | N | Write address ready, per master |
| m_awaddr | input | N*AW | Write addresses, master i at bits [i*AW +: AW] |
| m_wvalid | input | N | Write data valid, per master |
| m_wready | output | N | Write data ready, per master |
| m_wdata | input | N*DW | Write data, per master |
| m_wstrb | input | N*DW/8 | Write byte strobes, per master |
| m_bvalid | output | N | Write response valid, per master |
| m_bready | input | N | Write response ready, per master |
| m_bresp | output | N*2 | Write response code, per master |
| m_arvalid | input | N | Read address valid, per master |
| m_arready | output | N | Read address ready, per master |
| m_araddr | input | N*AW | Read addresses, per master |
| m_rvalid | output | N | Read data valid, per master |
| m_rready | input | N | Read data ready, per master |
| m_rdata | output | N*DW | Read data, per master |
| m_rresp | output | N*2 | Read response code, per master |
| s_awvalid | output | 1 | Slave write address valid |
| s_awready | input | 1 | Slave write address ready |
| s_awaddr | output | AW | Slave write address |
| s_wvalid | output | 1 | Slave write data valid |
| s_wready | input | 1 | Slave write data ready |
| s_wdata | output | DW | Slave write data |
| s_wstrb | output | DW/8 | Slave write strobes |
| s_bvalid | input | 1 | Slave write response valid |
| s_bready | output | 1 | Slave write response ready |
| s_bresp | input | 2 | Slave write response code |
| s_arvalid | output | 1 | Slave read address valid |
| s_arready | input | 1 | Slave read address ready |
| s_araddr | output | AW | Slave read address |
| s_rvalid | input | 1 | Slave read data valid |
| s_rready | output | 1 | Slave read data ready |
| s_rdata | input | DW | Slave read data |
| s_rresp | input | 2 | Slave read response code |

## Verification
A request that reaches an idle path shows up as a slave-side valid one cycle later, because the grant is registered. A kept grant reissues in the cycle right after the response handshake. Responses and ready signals pass through combinationally in the same cycle. The bench drives every input on the falling edge and samples one nanosecond later. Each model therefore records a handshake in the same cycle in which it occurs, and the bench never predicts a fixed cycle count. Ordering is checked by logging slave-side address acceptances and comparing them against expected order tables, while data, response codes and routing are checked per handshake at the master side.

// File: rtl/axil_arb_pkg.sv
package axil_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_RESP = 2'd2
    } arb_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/axil_rr_pick.sv
module axil_rr_pick #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    always_comb begin
        int j;
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            j = (int'(last) + k) % N;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/axil_arb_path.sv
module axil_arb_path
    import axil_arb_pkg::*;
#(
    parameter int N         = 3,
    parameter bit WITH_DATA = 1'b1,
    localparam int IDX_W    = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             addr_hs,
    input  logic             data_hs,
    input  logic             resp_hs,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             addr_en,
    output logic             data_en,
    output logic             resp_en
);

    arb_state_e       state, nxt;
    logic [IDX_W-1:0] last_idx;
    logic             addr_done, data_done;
    logic             found;
    logic [IDX_W-1:0] pick;
    logic             addr_ok, data_ok, keep, enter_addr;

    axil_rr_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
        .req   (req),
        .last  (last_idx),
        .found (found),
        .pick  (pick)
    );

    assign addr_ok    = addr_done | addr_hs;
    assign data_ok    = WITH_DATA ? (data_done | data_hs) : 1'b1;
    assign keep       = resp_hs & req[gnt_idx];
    assign enter_addr = ((state == ST_IDLE) && found) || ((state == ST_RESP) && keep);

    // next-state process
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (found)             nxt = ST_ADDR;   // arbitrate
            ST_ADDR: if (addr_ok && data_ok) nxt = ST_RESP;  // issued
            ST_RESP: if (resp_hs)           nxt = keep ? ST_ADDR : ST_IDLE; // keep / release
            default:                        nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // grant and progress registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_idx   <= '0;
            last_idx  <= IDX_W'(N - 1);
            addr_done <= 1'b0;
            data_done <= 1'b0;
        end else begin
            if (state == ST_IDLE && found) begin
                gnt_idx  <= pick;
                last_idx <= pick;
            end
            if (enter_addr) begin
                addr_done <= 1'b0;
                data_done <= 1'b0;
            end else if (state == ST_ADDR) begin
                if (addr_hs) addr_done <= 1'b1;
                if (data_hs) data_done <= 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        addr_en = 1'b0;
        data_en = 1'b0;
        resp_en = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR: begin
                addr_en = !addr_done;
                data_en = WITH_DATA && !data_done;
            end
            ST_RESP: resp_en = 1'b1;
            default: ;
        endcase
    end

    AST_HOLD_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP && !resp_hs) |=> (state == ST_RESP && $stable(gnt_idx))); // R4
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP && resp_hs && req[gnt_idx]) |=> (state == ST_ADDR && $stable(gnt_idx))); // R2
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP && resp_hs && !req[gnt_idx]) |=> (state == ST_IDLE)); // R3
    AST_NO_ADDR_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RESP) |-> !addr_hs); // R4

endmodule

// File: rtl/axil_rr_arbiter.sv
module axil_rr_arbiter
    import axil_arb_pkg::*;
#(
    parameter int N     = 3,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int SW   = DW / 8,
    localparam int IDX_W = idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    m_awvalid,
    output logic [N-1:0]    m_awready,
    input  logic [N*AW-1:0] m_awaddr,
    input  logic [N-1:0]    m_wvalid,
    output logic [N-1:0]    m_wready,
    input  logic [N*DW-1:0] m_wdata,
    input  logic [N*SW-1:0] m_wstrb,
    output logic [N-1:0]    m_bvalid,
    input  logic [N-1:0]    m_bready,
    output logic [N*2-1:0]  m_bresp,
    input  logic [N-1:0]    m_arvalid,
    output logic [N-1:0]    m_arready,
    input  logic [N*AW-1:0] m_araddr,
    output logic [N-1:0]    m_rvalid,
    input  logic [N-1:0]    m_rready,
    output logic [N*DW-1:0] m_rdata,
    output logic [N*2-1:0]  m_rresp,
    output logic            s_awvalid,
    input  logic            s_awready,
    output logic [AW-1:0]   s_awaddr,
    output logic            s_wvalid,
    input  logic            s_wready,
    output logic [DW-1:0]   s_wdata,
    output logic [SW-1:0]   s_wstrb,
    input  logic            s_bvalid,
    output logic            s_bready,
    input  logic [1:0]      s_bresp,
    output logic            s_arvalid,
    input  logic            s_arready,
    output logic [AW-1:0]   s_araddr,
    input  logic            s_rvalid,
    output logic            s_rready,
    input  logic [DW-1:0]   s_rdata,
    input  logic [1:0]      s_rresp
);

    logic [IDX_W-1:0] w_gnt, r_gnt;
    logic             w_addr_en, w_data_en, w_resp_en;
    logic             r_addr_en, r_data_en, r_resp_en;
    logic             rd_data_en_unused;

    assign rd_data_en_unused = r_data_en;

    axil_arb_path #(.N(N), .WITH_DATA(1'b1)) wr_path_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_awvalid),
        .addr_hs (s_awvalid & s_awready),
        .data_hs (s_wvalid & s_wready),
        .resp_hs (s_bvalid & s_bready),
        .gnt_idx (w_gnt),
        .addr_en (w_addr_en),
        .data_en (w_data_en),
        .resp_en (w_resp_en)
    );

    axil_arb_path #(.N(N), .WITH_DATA(1'b0)) rd_path_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (m_arvalid),
        .addr_hs (s_arvalid & s_arready),
        .data_hs (1'b0),
        .resp_hs (s_rvalid & s_rready),
        .gnt_idx (r_gnt),
        .addr_en (r_addr_en),
        .data_en (r_data_en),
        .resp_en (r_resp_en)
    );

    // slave-side multiplexing of the granted master
    assign s_awvalid = w_addr_en & m_awvalid[w_gnt];
    assign s_awaddr  = m_awaddr[w_gnt*AW +: AW];
    assign s_wvalid  = w_data_en & m_wvalid[w_gnt];
    assign s_wdata   = m_wdata[w_gnt*DW +: DW];
    assign s_wstrb   = m_wstrb[w_gnt*SW +: SW];
    assign s_bready  = w_resp_en & m_bready[w_gnt];
    assign s_arvalid = r_addr_en & m_arvalid[r_gnt];
    assign s_araddr  = m_araddr[r_gnt*AW +: AW];
    assign s_rready  = r_resp_en & m_rready[r_gnt];

    // master-side routing, only the granted master is driven
    for (genvar i = 0; i < N; i++) begin : g_mst
        logic w_sel, r_sel;
        assign w_sel = (w_gnt == IDX_W'(i));
        assign r_sel = (r_gnt == IDX_W'(i));
        assign m_awready[i]           = w_addr_en & w_sel & s_awready;
        assign m_wready[i]            = w_data_en & w_sel & s_wready;
        assign m_bvalid[i]            = w_resp_en & w_sel & s_bvalid;
        assign m_bresp[i*2 +: 2]      = (w_resp_en & w_sel) ? s_bresp : 2'b00;
        assign m_arready[i]           = r_addr_en & r_sel & s_arready;
        assign m_rvalid[i]            = r_resp_en & r_sel & s_rvalid;
        assign m_rresp[i*2 +: 2]      = (r_resp_en & r_sel) ? s_rresp : 2'b00;
        assign m_rdata[i*DW +: DW]    = (r_resp_en & r_sel) ? s_rdata : '0;
    end

    AST_AWREADY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_awready)); // R5
    AST_WREADY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_wready)); // R5
    AST_BVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_bvalid)); // R5
    AST_RVALID_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_rvalid)); // R5
    AST_ARREADY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(m_arready)); // R5

endmodule

// File: tb/axil_rr_arbiter_tb.sv
`timescale 1ns/1ps
module axil_rr_arbiter_tb_top;

    localparam int N  = 3;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam logic [31:0] ERR_ADDR = 32'h0000_02FC;

    // expected slave-side address orders
    localparam logic [31:0] EXP_STICKY [12] = '{
        32'h000, 32'h004, 32'h008, 32'h00C,
        32'h100, 32'h104, 32'h108, 32'h10C,
        32'h200, 32'h204, 32'h208, 32'h20C};
    localparam logic [31:0] EXP_ROTATE [12] = '{
        32'h000, 32'h100, 32'h200, 32'h004,
        32'h104, 32'h204, 32'h008, 32'h108,
        32'h208, 32'h00C, 32'h10C, 32'h20C};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    m_awvalid = '0, m_awready, m_wvalid = '0, m_wready;
    logic [N*AW-1:0] m_awaddr = '0, m_araddr = '0;
    logic [N*DW-1:0] m_wdata = '0, m_rdata;
    logic [N*SW-1:0] m_wstrb = '0;
    logic [N-1:0]    m_bvalid, m_bready = '0, m_arvalid = '0, m_arready, m_rvalid, m_rready = '0;
    logic [N*2-1:0]  m_bresp, m_rresp;
    logic            s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready;
    logic            s_awready = 1'b1, s_wready = 1'b1, s_arready = 1'b1;
    logic [AW-1:0]   s_awaddr, s_araddr;
    logic [DW-1:0]   s_wdata, s_rdata = '0;
    logic [SW-1:0]   s_wstrb;
    logic            s_bvalid = 1'b0, s_rvalid = 1'b0;
    logic [1:0]      s_bresp = 2'b00, s_rresp = 2'b00;

    axil_rr_arbiter #(.N(N), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
        .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata), .m_rresp(m_rresp),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp)
    );

    int n_checks = 0, n_errors = 0;
    int lat = 0;
    int ovl_err = 0, iso_err = 0, wdat_err = 0;
    logic [31:0] wr_log [64];
    logic [31:0] rd_log [64];
    int wr_n = 0, rd_n = 0;
    bit done_flag = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int m, input int n);
        return 32'(m * 256 + n * 4);
    endfunction

    function automatic logic [1:0] resp_of(input logic [31:0] a);
        return (a == ERR_ADDR) ? 2'b10 : 2'b00;
    endfunction

    // slave model: always ready, fixed response latency, logs address order
    initial begin
        bit aw_seen = 0, w_seen = 0, ar_seen = 0;
        logic [31:0] aw_a = '0, w_d = '0, ar_a = '0;
        logic [SW-1:0] w_s = '0;
        int bcnt = -1, rcnt = -1;
        bit b_hs = 0, r_hs = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                aw_seen = 0; w_seen = 0; ar_seen = 0; bcnt = -1; rcnt = -1;
                s_bvalid = 0; s_rvalid = 0; s_rdata = '0; b_hs = 0; r_hs = 0;
            end else begin
                if (b_hs) begin s_bvalid = 0; b_hs = 0; end
                if (r_hs) begin s_rvalid = 0; s_rdata = '0; r_hs = 0; end
                if (bcnt == 0) begin s_bvalid = 1; s_bresp = resp_of(aw_a); bcnt = -1; end
                else if (bcnt > 0) bcnt--;
                if (rcnt == 0) begin
                    s_rvalid = 1; s_rresp = resp_of(ar_a); s_rdata = ar_a ^ 32'hA5A5_0000; rcnt = -1;
                end else if (rcnt > 0) rcnt--;
            end
            #1;
            if (rst_n) begin
                if (s_awvalid && s_awready) begin
                    if (aw_seen) ovl_err++;
                    aw_seen = 1; aw_a = s_awaddr;
                    if (wr_n < 64) wr_log[wr_n] = s_awaddr;
                    wr_n++;
                end
                if (s_wvalid && s_wready) begin
                    if (w_seen) ovl_err++;
                    w_seen = 1; w_d = s_wdata; w_s = s_wstrb;
                end
                if (aw_seen && w_seen && bcnt < 0 && !s_bvalid && !b_hs) begin
                    if (w_d !== ~aw_a || w_s !== '1) wdat_err++;
                    bcnt = lat;
                end
                if (s_bvalid && s_bready) begin b_hs = 1; aw_seen = 0; w_seen = 0; end
                if (s_arvalid && s_arready) begin
                    if (ar_seen) ovl_err++;
                    ar_seen = 1; ar_a = s_araddr; rcnt = lat;
                    if (rd_n < 64) rd_log[rd_n] = s_araddr;
                    rd_n++;
                end
                if (s_rvalid && s_rready) begin r_hs = 1; ar_seen = 0; end
            end
        end
    end

    // isolation monitor (R5)
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if ($countones(m_awready) > 1 || $countones(m_arready) > 1 ||
                    $countones(m_bvalid) > 1 || $countones(m_rvalid) > 1) iso_err++;
                for (int i = 0; i < N; i++) begin
                    if (!m_rvalid[i] && (m_rdata[i*DW +: DW] != '0 || m_rresp[i*2 +: 2] != 2'b00)) iso_err++;
                    if (!m_bvalid[i] && m_bresp[i*2 +: 2] != 2'b00) iso_err++;
                end
            end
        end
    end

    // master model: rd selects the path, b2b keeps the next request up while waiting
    task automatic run_master(input int m, input bit rd, input int cnt, input bit b2b, input int start);
        int issued = 0, done = 0;
        bit pa = 0, pd = 0, acc;
        logic [31:0] a, ea;
        while (done < cnt) begin
            @(negedge clk);
            if (!pa && !pd && issued < cnt && (issued == done || (b2b && issued - done == 1))) begin
                a = addr_of(m, start + issued);
                issued++; pa = 1; pd = !rd;
                if (rd) m_araddr[m*AW +: AW] = a;
                else begin
                    m_awaddr[m*AW +: AW] = a;
                    m_wdata[m*DW +: DW]  = ~a;
                    m_wstrb[m*SW +: SW]  = '1;
                end
            end
            acc = (issued - done == 2) || (issued - done == 1 && !pa && !pd);
            if (rd) begin m_arvalid[m] = pa; m_rready[m] = acc; end
            else begin m_awvalid[m] = pa; m_wvalid[m] = pd; m_bready[m] = acc; end
            #1;
            ea = addr_of(m, start + done);
            if (rd) begin
                if (m_arvalid[m] && m_arready[m]) pa = 0;
                if (m_rready[m] && m_rvalid[m]) begin
                    chk(m_rdata[m*DW +: DW] == (ea ^ 32'hA5A5_0000), "R7", "read data",
                        m_rdata[m*DW +: DW], ea ^ 32'hA5A5_0000);
                    chk(m_rresp[m*2 +: 2] == resp_of(ea), "R7", "read resp",
                        32'(m_rresp[m*2 +: 2]), 32'(resp_of(ea)));
                    done++;
                end
            end else begin
                if (m_awvalid[m] && m_awready[m]) pa = 0;
                if (m_wvalid[m] && m_wready[m]) pd = 0;
                if (m_bready[m] && m_bvalid[m]) begin
                    chk(m_bresp[m*2 +: 2] == resp_of(ea), "R7", "write resp",
                        32'(m_bresp[m*2 +: 2]), 32'(resp_of(ea)));
                    done++;
                end
            end
        end
        @(negedge clk);
        if (rd) begin m_arvalid[m] = 0; m_rready[m] = 0; end
        else begin m_awvalid[m] = 0; m_wvalid[m] = 0; m_bready[m] = 0; end
    endtask

    task automatic run_all(input int cnt, input bit b2b);
        fork
            run_master(0, 0, cnt, b2b, 0);
            run_master(1, 0, cnt, b2b, 0);
            run_master(2, 0, cnt, b2b, 0);
            run_master(0, 1, cnt, b2b, 0);
            run_master(1, 1, cnt, b2b, 0);
            run_master(2, 1, cnt, b2b, 0);
        join
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        m_awvalid = '0; m_wvalid = '0; m_bready = '0; m_arvalid = '0; m_rready = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        wr_n = 0; rd_n = 0;
    endtask

    task automatic check_order(input string req, input bit sticky);
        chk(wr_n == 12, req, "write count", 32'(wr_n), 32'd12);
        chk(rd_n == 12, req, "read count", 32'(rd_n), 32'd12);
        for (int k = 0; k < 12; k++) begin
            logic [31:0] e;
            e = sticky ? EXP_STICKY[k] : EXP_ROTATE[k];
            chk(wr_log[k] == e, req, $sformatf("write order #%0d", k), wr_log[k], e);
            chk(rd_log[k] == e, req, $sformatf("read order #%0d (R6)", k), rd_log[k], e);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: requests during reset are not passed through
        rst_n = 0;
        m_awvalid = '1; m_arvalid = '1; m_wvalid = '1;
        repeat (2) @(negedge clk);
        #1;
        chk(m_awready == '0 && m_arready == '0 && m_wready == '0, "R1", "ready in reset",
            32'({m_awready, m_arready}), 32'd0);
        chk(!s_awvalid && !s_arvalid && !s_wvalid, "R1", "slave valid in reset",
            32'({s_awvalid, s_arvalid, s_wvalid}), 32'd0);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(!s_awvalid && !s_arvalid && m_bvalid == '0 && m_rvalid == '0, "R1",
            "first cycle after reset", 32'({s_awvalid, s_arvalid}), 32'd0);
        m_awvalid = '0; m_arvalid = '0; m_wvalid = '0;
        do_reset();

        // R2 / R6: back-to-back masters keep the grant
        lat = 0;
        run_all(4, 1'b1);
        check_order("R2", 1'b1);

        // R3 / R1: idle gaps give round robin starting from master 0
        do_reset();
        run_all(4, 1'b0);
        check_order("R3", 1'b0);

        // R4: response latency 3, both patterns
        lat = 3;
        do_reset();
        run_all(4, 1'b1);
        check_order("R4", 1'b1);
        do_reset();
        run_all(4, 1'b0);
        check_order("R4", 1'b0);
        chk(ovl_err == 0, "R4", "overlapping transactions", 32'(ovl_err), 32'd0);
        lat = 0;

        // R3: rotation starts after last granted master, skipping idle ones
        do_reset();
        run_master(1, 0, 1, 1'b0, 0);
        fork
            run_master(0, 0, 1, 1'b0, 0);
            run_master(2, 0, 1, 1'b0, 0);
        join
        chk(wr_n == 3, "R3", "rotation count", 32'(wr_n), 32'd3);
        chk(wr_log[0] == 32'h100, "R3", "rotation #0", wr_log[0], 32'h100);
        chk(wr_log[1] == 32'h200, "R3", "rotation #1", wr_log[1], 32'h200);
        chk(wr_log[2] == 32'h000, "R3", "rotation #2", wr_log[2], 32'h000);

        // R7: error response passes through on both paths
        do_reset();
        fork
            run_master(2, 0, 1, 1'b0, 63);
            run_master(2, 1, 1, 1'b0, 63);
        join
        chk(wr_n == 1 && rd_n == 1, "R7", "error txn count", 32'(wr_n + rd_n), 32'd2);

        chk(wdat_err == 0, "R8", "write data/strobe mismatches", 32'(wdat_err), 32'd0);
        chk(iso_err == 0, "R5", "non-granted master exposure", 32'(iso_err), 32'd0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule